// File: doc/BRIEF.md
# Standby Power Sequencer with Fail-Safe Off

This block sequences a system into and out of Standby. It drives two independent power enables, one for working power and one for auxiliary power, together with an active-low reset and an enable for the interface to logic on working power. Software asks for Standby by pulsing a request to drop working power, auxiliary power or both. The block then asserts reset and closes the interface before it removes any power. Reset stays asserted for the whole Standby period.

A wake pulse brings working power back at once. Reset stays asserted until a programmable number of slow-clock ticks has elapsed. When reset is released, a sticky flag records that the system came back from Standby, and software clears that flag by writing a one. A debounced on/off button acts as a fail-safe. If the button is held for a programmable number of ticks, both power enables drop unconditionally, whatever the sequencer is doing at that moment.

Top module: `stby_pwr_seq`

## Requirements
- R1: On a software drop request in the running state, `rst_n_out` and `if_en` go low one cycle after the request. Power is removed one cycle after that, so a power enable never falls while reset is high or the interface is enabled.
- R2: While working power is off, `rst_n_out` stays low. A wake pulse is the only exit from Standby apart from the fail-safe.
- R3: Each power enable is dropped only by its own request. `sw_work_off` alone leaves `aux_pwr` following `aux_en`, and `sw_aux_off` alone leaves `work_pwr` high. In either case reset is asserted.
- R4: On a wake pulse in Standby, `work_pwr` rises one cycle after the pulse. `rst_n_out` rises once `rel_dly` ticks have been counted in the waking state, and with `rel_dly` = 0 it rises one cycle after `work_pwr`.
- R5: `stby_flag` is set on the cycle that `rst_n_out` is released after a wake and stays set until `stat_clr` is pulsed. If both happen together, setting takes priority.
- R6: When `btn` has been high for `hold_time` ticks (0 is treated as 1), both power enables drop on the next cycle, reset asserts and `if_en` drops, from any state. The fail-safe does not fire again until the button is released.
- R7: Releasing `btn` before the hold time is reached resets the hold count to zero, so the next press must last the full hold time.
- R8: Outside Standby, and in Standby while auxiliary power has not been cut, `aux_pwr` follows `aux_en` with one cycle of delay, including during the reset-release wait after a wake.
- R9: A wake pulse in the running state has no effect. Drop requests during the waking state have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow-clock enable, one cycle wide |
| sw_work_off | input | 1 | Request pulse to drop working power |
| sw_aux_off | input | 1 | Request pulse to drop auxiliary power |
| aux_en | input | 1 | Desired auxiliary power level when not cut |
| wake | input | 1 | Wake event pulse |
| btn | input | 1 | Debounced on/off button, high when pressed |
| rel_dly | input | DLY_W | Reset release delay in ticks |
| hold_time | input | HOLD_W | Fail-safe hold time in ticks |
| stat_clr | input | 1 | Write-one pulse clearing the wake status |
| work_pwr | output | 1 | Working power enable |
| aux_pwr | output | 1 | Auxiliary power enable |
| rst_n_out | output | 1 | Active-low system reset |
| if_en | output | 1 | Interface enable toward working-power logic |
| stby_flag | output | 1 | Sticky flag: woke from Standby |

## Verification
The bench targets the ordering between reset and power removal. A design that drops power in the same cycle as the request would let working-power logic see power fail while it is still out of reset. It also covers a zero release delay, where an off-by-one counter would either hold reset for an extra tick or release it before power returns. An early button release must clear the hold count; a design that only pauses the count would cut power on a second short press. A button still held after the fail-safe has fired must not fire again, or the system would drop power repeatedly while it is waking.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_STBY  = 2'd2,
    ST_WAKE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/stby_tick_cnt.sv
module stby_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && !hit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stby_seq_fsm.sv
module stby_seq_fsm
  import stby_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fail_safe,
  input  logic rel_hit,
  input  logic sw_work_off,
  input  logic sw_aux_off,
  input  logic aux_en,
  input  logic wake,
  input  logic stat_clr,
  output logic in_wake,
  output logic work_pwr,
  output logic aux_pwr,
  output logic rst_n_out,
  output logic if_en,
  output logic stby_flag
);
  seq_state_t state;
  logic pend_w, pend_a, aux_cut, set_flag;

  assign in_wake  = (state == ST_WAKE);
  assign set_flag = !fail_safe && (state == ST_WAKE) && rel_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      pend_w    <= 1'b0;
      pend_a    <= 1'b0;
      aux_cut   <= 1'b0;
      work_pwr  <= 1'b1;
      aux_pwr   <= 1'b0;
      rst_n_out <= 1'b1;
      if_en     <= 1'b1;
    end else if (fail_safe) begin
      state     <= ST_STBY;
      aux_cut   <= 1'b1;
      work_pwr  <= 1'b0;
      aux_pwr   <= 1'b0;
      rst_n_out <= 1'b0;
      if_en     <= 1'b0;
    end else begin
      unique case (state)
        ST_RUN: begin
          aux_pwr <= aux_en;
          if (sw_work_off || sw_aux_off) begin
            state     <= ST_ENTER;
            pend_w    <= sw_work_off;
            pend_a    <= sw_aux_off;
            rst_n_out <= 1'b0;
            if_en     <= 1'b0;
          end
        end
        ST_ENTER: begin
          state    <= ST_STBY;
          aux_cut  <= pend_a;
          work_pwr <= !pend_w;
          aux_pwr  <= aux_en && !pend_a;
        end
        ST_STBY: begin
          if (wake) begin
            state    <= ST_WAKE;
            aux_cut  <= 1'b0;
            work_pwr <= 1'b1;
            aux_pwr  <= aux_en;
          end else begin
            aux_cut  <= aux_cut || sw_aux_off;
            work_pwr <= work_pwr && !sw_work_off;
            aux_pwr  <= aux_en && !(aux_cut || sw_aux_off);
          end
        end
        ST_WAKE: begin
          aux_pwr <= aux_en;
          if (rel_hit) begin
            state     <= ST_RUN;
            rst_n_out <= 1'b1;
            if_en     <= 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stby_flag <= 1'b0;
    else if (set_flag) stby_flag <= 1'b1;
    else if (stat_clr) stby_flag <= 1'b0;
  end
endmodule

// File: rtl/stby_pwr_seq.sv
module stby_pwr_seq #(
  parameter int DLY_W  = 16,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              sw_work_off,
  input  logic              sw_aux_off,
  input  logic              aux_en,
  input  logic              wake,
  input  logic              btn,
  input  logic [DLY_W-1:0]  rel_dly,
  input  logic [HOLD_W-1:0] hold_time,
  input  logic              stat_clr,
  output logic              work_pwr,
  output logic              aux_pwr,
  output logic              rst_n_out,
  output logic              if_en,
  output logic              stby_flag
);
  localparam logic [HOLD_W-1:0] HOLD_MIN = HOLD_W'(1);

  logic [HOLD_W-1:0] hold_lim;
  logic hold_hit, rel_hit, fired, fail_safe, in_wake;

  assign hold_lim  = (hold_time == '0) ? HOLD_MIN : hold_time;
  assign fail_safe = btn && hold_hit && !fired;

  stby_tick_cnt #(.W(HOLD_W)) u_hold (
    .clk (clk),
    .rst (rst),
    .clr (!btn),
    .inc (tick),
    .lim (hold_lim),
    .hit (hold_hit)
  );

  stby_tick_cnt #(.W(DLY_W)) u_rel (
    .clk (clk),
    .rst (rst),
    .clr (!in_wake),
    .inc (tick),
    .lim (rel_dly),
    .hit (rel_hit)
  );

  always_ff @(posedge clk) begin
    if (rst || !btn) fired <= 1'b0;
    else if (fail_safe) fired <= 1'b1;
  end

  stby_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .fail_safe   (fail_safe),
    .rel_hit     (rel_hit),
    .sw_work_off (sw_work_off),
    .sw_aux_off  (sw_aux_off),
    .aux_en      (aux_en),
    .wake        (wake),
    .stat_clr    (stat_clr),
    .in_wake     (in_wake),
    .work_pwr    (work_pwr),
    .aux_pwr     (aux_pwr),
    .rst_n_out   (rst_n_out),
    .if_en       (if_en),
    .stby_flag   (stby_flag)
  );
endmodule

// File: rtl/stby_pwr_seq_chk.sv
module stby_pwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic work_pwr,
  input logic rst_n_out,
  input logic if_en,
  input logic stby_flag
);
  AST_PWR_FALL_IN_RST: assert property (@(posedge clk) disable iff (rst)
    $fell(work_pwr) |-> (!rst_n_out && !if_en)); // R1
  AST_IF_OFF_IN_RST: assert property (@(posedge clk) disable iff (rst)
    !rst_n_out |-> !if_en); // R1
  AST_RST_HELD_STBY: assert property (@(posedge clk) disable iff (rst)
    !work_pwr |-> !rst_n_out); // R2
  AST_REL_AFTER_PWR: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_out) |-> (work_pwr && $past(work_pwr))); // R4
  AST_FLAG_ON_REL: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_out) |-> stby_flag); // R5
endmodule

bind stby_pwr_seq stby_pwr_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .work_pwr  (work_pwr),
  .rst_n_out (rst_n_out),
  .if_en     (if_en),
  .stby_flag (stby_flag)
);

// File: tb/stby_pwr_seq_test.sv
`timescale 1ns/1ps
module stby_pwr_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic sw_work_off = 1'b0, sw_aux_off = 1'b0, aux_en = 1'b1, wake = 1'b0;
  logic btn = 1'b0, stat_clr = 1'b0;
  logic [15:0] rel_dly = 16'd3, hold_time = 16'd5;
  logic work_pwr, aux_pwr, rst_n_out, if_en, stby_flag;

  int errors = 0, checks = 0, cycles = 0, tdiv = 0;

  always #2 clk = ~clk;

  stby_pwr_seq #(.DLY_W(16), .HOLD_W(16)) uut (
    .clk(clk), .rst(rst), .tick(tick), .sw_work_off(sw_work_off),
    .sw_aux_off(sw_aux_off), .aux_en(aux_en), .wake(wake), .btn(btn),
    .rel_dly(rel_dly), .hold_time(hold_time), .stat_clr(stat_clr),
    .work_pwr(work_pwr), .aux_pwr(aux_pwr), .rst_n_out(rst_n_out),
    .if_en(if_en), .stby_flag(stby_flag)
  );

  always @(posedge clk) begin
    tdiv <= (tdiv + 1) % 4;
    tick <= (tdiv == 3);
  end

  // Behavioural reference: 0 run, 1 entering, 2 standby, 3 waking
  int mst, hcnt, rcnt, lim;
  bit m_work, m_aux, m_rstn, m_if, m_flag, m_pw, m_pa, m_cut, m_fired;
  always @(posedge clk) begin
    bit fs, hhit, rhit, setf;
    if (rst) begin
      mst = 0; hcnt = 0; rcnt = 0; m_fired = 0; m_cut = 0; m_pw = 0; m_pa = 0;
      m_work = 1; m_aux = 0; m_rstn = 1; m_if = 1; m_flag = 0;
    end else begin
      lim  = (hold_time == 0) ? 1 : int'(hold_time);
      hhit = (hcnt >= lim);
      rhit = (rcnt >= int'(rel_dly));
      fs   = btn && hhit && !m_fired;
      setf = 0;
      if (!btn) hcnt = 0; else if (tick && !hhit) hcnt++;
      if (!btn) m_fired = 0; else if (fs) m_fired = 1;
      if (mst != 3) rcnt = 0; else if (tick && !rhit) rcnt++;
      if (fs) begin
        mst = 2; m_cut = 1; m_work = 0; m_aux = 0; m_rstn = 0; m_if = 0;
      end else if (mst == 0) begin
        m_aux = aux_en;
        if (sw_work_off || sw_aux_off) begin
          mst = 1; m_pw = sw_work_off; m_pa = sw_aux_off; m_rstn = 0; m_if = 0;
        end
      end else if (mst == 1) begin
        mst = 2; m_cut = m_pa; m_work = !m_pw; m_aux = aux_en && !m_pa;
      end else if (mst == 2) begin
        if (wake) begin
          mst = 3; m_cut = 0; m_work = 1; m_aux = aux_en;
        end else begin
          m_aux = aux_en && !(m_cut || sw_aux_off);
          m_cut = m_cut || sw_aux_off;
          m_work = m_work && !sw_work_off;
        end
      end else begin
        m_aux = aux_en;
        if (rhit) begin mst = 0; m_rstn = 1; m_if = 1; setf = 1; end
      end
      if (setf) m_flag = 1; else if (stat_clr) m_flag = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(work_pwr == m_work, "R3 work_pwr vs model", work_pwr, m_work);
      check(aux_pwr == m_aux, "R8 aux_pwr vs model", aux_pwr, m_aux);
      check(rst_n_out == m_rstn, "R2 rst_n_out vs model", rst_n_out, m_rstn);
      check(if_en == m_if, "R1 if_en vs model", if_en, m_if);
      check(stby_flag == m_flag, "R5 stby_flag vs model", stby_flag, m_flag);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    @(negedge clk);
    check(work_pwr && rst_n_out && if_en && !stby_flag, "reset state", work_pwr, 1);
    // R9: wake while running changes nothing
    step(1); wake = 1; step(1); wake = 0; step(1);
    @(negedge clk);
    check(rst_n_out == 1 && work_pwr == 1, "R9 wake in run", rst_n_out, 1);
    // R1: reset before power drop
    step(1); sw_work_off = 1; step(1); sw_work_off = 0;
    @(negedge clk);
    check(!rst_n_out && !if_en && work_pwr, "R1 reset first", work_pwr, 1);
    step(1); @(negedge clk);
    check(!work_pwr, "R1 power dropped", work_pwr, 0);
    check(aux_pwr, "R3 aux kept", aux_pwr, 1);
    // R2: held through standby
    step(10); @(negedge clk);
    check(!rst_n_out, "R2 reset held", rst_n_out, 0);
    // R4: wake
    wake = 1; step(1); wake = 0;
    @(negedge clk);
    check(work_pwr && !rst_n_out, "R4 power back, reset held", rst_n_out, 0);
    // R9: drop request during wake ignored
    sw_aux_off = 1; step(1); sw_aux_off = 0;
    @(negedge clk);
    check(aux_pwr, "R9 request in wake ignored", aux_pwr, 1);
    // R8: aux follows enable while waking
    aux_en = 0; step(1); @(negedge clk);
    check(!aux_pwr, "R8 aux follows low", aux_pwr, 0);
    aux_en = 1; step(1); @(negedge clk);
    check(aux_pwr, "R8 aux follows high", aux_pwr, 1);
    for (int i = 0; i < 40 && !rst_n_out; i++) step(1);
    @(negedge clk);
    check(rst_n_out, "R4 reset released", rst_n_out, 1);
    check(stby_flag, "R5 flag set", stby_flag, 1);
    step(1); stat_clr = 1; step(1); stat_clr = 0;
    @(negedge clk);
    check(!stby_flag, "R5 flag cleared", stby_flag, 0);
    // R3: aux only
    sw_aux_off = 1; step(1); sw_aux_off = 0; step(1);
    @(negedge clk);
    check(!aux_pwr && work_pwr && !rst_n_out, "R3 aux only dropped", aux_pwr, 0);
    // R4: zero release delay
    rel_dly = 0; wake = 1; step(1); wake = 0;
    @(negedge clk);
    check(!rst_n_out && work_pwr, "R4 zero delay wake", rst_n_out, 0);
    step(1); @(negedge clk);
    check(rst_n_out, "R4 zero delay release", rst_n_out, 1);
    // R7: early release clears the hold count
    btn = 1; step(12); btn = 0; step(1); btn = 1; step(12);
    @(negedge clk);
    check(work_pwr, "R7 early release no fire", work_pwr, 1);
    // R6: full hold fires
    step(12); @(negedge clk);
    check(!work_pwr && !aux_pwr && !rst_n_out, "R6 fail-safe off", work_pwr, 0);
    // R6: no refire while still held
    wake = 1; step(1); wake = 0; step(20);
    @(negedge clk);
    check(work_pwr && rst_n_out, "R6 no refire while held", work_pwr, 1);
    btn = 0; step(10);
    finish_run();
  end
endmodule